// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Queueing

This block is the sending half of an asynchronous serial port. Software writes a byte into a one-entry holding register. At the next character boundary the byte moves into a shift register. It leaves on a single output line as a start bit, the data bits least-significant first, an optional parity bit and a stop bit. Each bit lasts one period of an externally divided baud enable.

An all-ones idle character goes out whenever the transmit enable turns on. An idle character can also be queued behind the frame in flight by dropping the enable and raising it again quickly. The line polarity can be inverted. Two status flags report "holding register free" and "everything sent", and each has its own interrupt mask.

Top module: `serial_tx_idleq`

## Requirements
- R1: Out of reset, with the inversion control at 0, `txd` is 1, `st_empty` is 1 and `st_done` is 1.
- R2: A data frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Every bit lasts exactly one baud tick. With `cfg_nine`=0 the frame carries 8 data bits (10 bit times). With `cfg_nine`=1, `cfg_bit8` is sent as a ninth data bit (11 bit times).
- R3: With `cfg_par_en`=1, the parity bit replaces the highest data bit: bit 7 in 8-bit mode, bit 8 in 9-bit mode. It is computed over the lower data bits. With `cfg_par_odd`=0 the total number of ones is even; with 1 it is odd.
- R4: A 0-to-1 change of `tx_en` arms an idle character. That character starts at the first baud tick at least one clock after the edge that saw `tx_en` high. It is all ones and lasts 10 bit times (8-bit mode) or 11 (9-bit mode).
- R5: A byte waiting in the holding register starts at the tick that ends the previous character, so frames run back to back. `st_empty` becomes 1 at that same tick edge.
- R6: If `tx_en` falls during a frame, the frame still completes. The line then stays idle, and a waiting byte stays held (`st_empty` remains 0).
- R7: If `tx_en` falls and rises again while a data frame is still before its stop bit, one idle character follows that frame, then the held byte. The held byte is not discarded.
- R8: A rise of `tx_en` while the stop bit is being driven, or while no data frame is running, discards any held byte (`st_empty` becomes 1 on the next cycle). It is followed by an idle character.
- R9: With `cfg_inv`=1 every level on `txd` is inverted, including idle, start and stop levels.
- R10: A `wr_stb` pulse clears `st_empty` and `st_done` on the following cycle.
- R11: `st_done` is 1 only when the holding register is empty, no character is being shifted and no idle character is armed.
- R12: `irq` is high when (`st_empty` and `cfg_ie_empty`) or (`st_done` and `cfg_ie_done`).
- R13: `txd` changes only at clock edges where `baud_tick` is high, or when `cfg_inv` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle bit-period enable |
| tx_en | input | 1 | Transmit enable level |
| cfg_nine | input | 1 | 1 selects 9 data bits per frame |
| cfg_bit8 | input | 1 | Ninth data bit in 9-bit mode |
| cfg_par_en | input | 1 | Parity replaces the top data bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_inv | input | 1 | Invert every level on the line |
| cfg_ie_empty | input | 1 | Interrupt mask for holding-register-free |
| cfg_ie_done | input | 1 | Interrupt mask for all-sent |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial line |
| st_empty | output | 1 | Holding register free |
| st_done | output | 1 | Nothing held, shifting or armed |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the enable-toggle timing. It drops and restores the enable during an early data bit and again during the stop bit. A design that misjudged the window would either lose the second byte where it should have queued an idle character, or send that byte without the idle gap. Back-to-back frames are timed to the exact tick, so an off-by-one in the bit counter shows up as a gap or an overlap. The bench also checks parity placement in both character lengths and the 11-bit idle length of 9-bit mode. A parity bit on the wrong data position, or an idle character of the wrong length, shifts every later bit.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic {
      K_IDLE = 1'b0,
      K_DATA = 1'b1
   } stx_kind_e;

   // index of the final bit time of a character
   function automatic int unsigned char_last(input int unsigned dw, input logic nine);
      return nine ? dw + 2 : dw + 1;
   endfunction
endpackage

// File: rtl/stx_holdreg.sv
module stx_holdreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   input  logic              flush,
   output logic [DATA_W-1:0] data,
   output logic              empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         empty <= 1'b1;
      end else if (wr) begin
         data  <= wdata;
         empty <= 1'b0;
      end else if (take || flush) begin
         empty <= 1'b1;
      end
   end
endmodule

// File: rtl/stx_framer.sv
module stx_framer #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic              nine,
   input  logic              bit8,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W+2:0] vec
);
   logic use_par;
   logic par_lo;
   logic par_hi;

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par = par_en;
         assign par_lo  = (^data[DATA_W-2:0]) ^ par_odd;
         assign par_hi  = (^data) ^ par_odd;
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_en ^ par_odd;
         assign use_par    = 1'b0;
         assign par_lo     = 1'b0;
         assign par_hi     = 1'b0;
      end
   endgenerate

   always_comb begin
      vec           = '1;
      vec[0]        = 1'b0;
      vec[DATA_W:1] = data;
      if (nine) begin
         vec[DATA_W+1] = use_par ? par_hi : bit8;
      end else if (use_par) begin
         vec[DATA_W] = par_lo;
      end
   end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              nine,
   input  logic              hold_empty,
   input  logic [DATA_W+2:0] frame_vec,
   output logic              take,
   output logic              flush,
   output logic              busy,
   output logic              pending,
   output logic              line
);
   localparam int unsigned FW    = DATA_W + 3;
   localparam int unsigned CNT_W = $clog2(FW);
   localparam logic [CNT_W-1:0] L8 = CNT_W'(char_last(DATA_W, 1'b0));
   localparam logic [CNT_W-1:0] L9 = CNT_W'(char_last(DATA_W, 1'b1));

   logic              en_q;
   logic              pend_pre;
   logic              qidle;
   stx_kind_e         kind;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last;
   logic [FW-1:0]     sh;

   logic rise, at_end, in_window, slot, go, go_idle, go_data;

   assign rise      = en & ~en_q;
   assign at_end    = busy & (cnt == last);
   assign in_window = busy & (kind == K_DATA) & (cnt < last);
   assign slot      = tick & (~busy | at_end);
   assign go        = slot & en & en_q;
   assign go_idle   = go & (pend_pre | qidle);
   assign go_data   = go & ~go_idle & ~hold_empty;

   assign take    = go_data;
   assign flush   = rise & ~in_window;
   assign pending = busy | pend_pre | qidle;
   assign line    = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         pend_pre <= 1'b0;
         qidle    <= 1'b0;
         busy     <= 1'b0;
         kind     <= K_IDLE;
         cnt      <= '0;
         last     <= '0;
         sh       <= '1;
      end else begin
         en_q <= en;

         if (!en)          pend_pre <= 1'b0;
         else if (flush)   pend_pre <= 1'b1;
         else if (go_idle) pend_pre <= 1'b0;

         if (rise && in_window)           qidle <= 1'b1;
         else if (go_idle || (slot && !en)) qidle <= 1'b0;

         if (tick && busy && !at_end) begin
            cnt <= cnt + CNT_W'(1);
            sh  <= {1'b1, sh[FW-1:1]};
         end else if (slot) begin
            cnt <= '0;
            if (go_idle) begin
               busy <= 1'b1;
               kind <= K_IDLE;
               last <= nine ? L9 : L8;
               sh   <= '1;
            end else if (go_data) begin
               busy <= 1'b1;
               kind <= K_DATA;
               last <= nine ? L9 : L8;
               sh   <= frame_vec;
            end else begin
               busy <= 1'b0;
               kind <= K_IDLE;
               sh   <= '1;
            end
         end
      end
   end
endmodule

// File: rtl/serial_tx_idleq.sv
module serial_tx_idleq #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              cfg_nine,
   input  logic              cfg_bit8,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_inv,
   input  logic              cfg_ie_empty,
   input  logic              cfg_ie_done,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              st_empty,
   output logic              st_done,
   output logic              irq
);
   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("serial_tx_idleq: DATA_W must lie in 2..16");
      end
   endgenerate

   logic [DATA_W-1:0] hold_data;
   logic [DATA_W+2:0] frame_vec;
   logic              take, flush, shf_busy, shf_pending, line;

   stx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_stb),
      .wdata (wr_data),
      .take  (take),
      .flush (flush),
      .data  (hold_data),
      .empty (st_empty)
   );

   stx_framer #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_framer (
      .nine    (cfg_nine),
      .bit8    (cfg_bit8),
      .par_en  (cfg_par_en),
      .par_odd (cfg_par_odd),
      .data    (hold_data),
      .vec     (frame_vec)
   );

   stx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .en         (tx_en),
      .nine       (cfg_nine),
      .hold_empty (st_empty),
      .frame_vec  (frame_vec),
      .take       (take),
      .flush      (flush),
      .busy       (shf_busy),
      .pending    (shf_pending),
      .line       (line)
   );

   assign txd     = line ^ cfg_inv;
   assign st_done = st_empty & ~shf_pending;
   assign irq     = (st_empty & cfg_ie_empty) | (st_done & cfg_ie_done);
endmodule

// File: rtl/serial_tx_idleq_chk.sv
module serial_tx_idleq_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_en,
   input logic cfg_inv,
   input logic cfg_ie_empty,
   input logic cfg_ie_done,
   input logic wr_stb,
   input logic txd,
   input logic st_empty,
   input logic st_done,
   input logic irq
);
   // R13: level only moves on a bit-period edge
   a_r13_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(baud_tick) && $stable(cfg_inv)) |-> $stable(txd));

   // R10
   a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (!st_empty && !st_done));

   // R11
   a_r11_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> st_empty);

   // R11: nothing in flight means the line rests at idle
   a_r11_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> (txd == ~cfg_inv));

   // R5 / R8: the register frees only by a hand-over tick or an enable rise
   a_r5_empty_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_empty) |-> ($past(baud_tick) || ($past(tx_en) && !$past(tx_en, 2))));

   // R12
   a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ie_empty && !cfg_ie_done) |-> !irq);
endmodule

bind serial_tx_idleq serial_tx_idleq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .baud_tick    (baud_tick),
   .tx_en        (tx_en),
   .cfg_inv      (cfg_inv),
   .cfg_ie_empty (cfg_ie_empty),
   .cfg_ie_done  (cfg_ie_done),
   .wr_stb       (wr_stb),
   .txd          (txd),
   .st_empty     (st_empty),
   .st_done      (st_done),
   .irq          (irq)
);

// File: tb/serial_tx_idleq_tb.sv
module serial_tx_idleq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_en = 1'b0;
   logic       cfg_nine = 1'b0, cfg_bit8 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic       cfg_inv = 1'b0, cfg_ie_empty = 1'b0, cfg_ie_done = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, st_empty, st_done, irq;

   int nchk = 0;
   int nfail = 0;
   int tk = 0;
   logic samp [0:8191];
   int stab_viol = 0;
   logic lvl_prev = 1'b1;

   always #5 clk = ~clk;

   serial_tx_idleq u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .cfg_nine(cfg_nine), .cfg_bit8(cfg_bit8), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_inv(cfg_inv), .cfg_ie_empty(cfg_ie_empty),
      .cfg_ie_done(cfg_ie_done), .wr_stb(wr_stb), .wr_data(wr_data),
      .txd(txd), .st_empty(st_empty), .st_done(st_done), .irq(irq)
   );

   // baud enable: one cycle high in every four
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   // line monitor: one sample per bit period, plus hold check (R13)
   always begin
      @(posedge clk);
      if (rst_n) begin
         automatic logic was_tick = baud_tick;
         #1;
         if (!was_tick && ((txd ^ cfg_inv) !== lvl_prev)) stab_viol++;
         lvl_prev = txd ^ cfg_inv;
         if (was_tick) begin
            if (tk < 8192) samp[tk] = txd;
            tk++;
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog (all requirements): got no completion, expected finish before 150000 cycles");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wait_tick();
      do @(posedge clk); while (!baud_tick);
      @(negedge clk);
   endtask

   task automatic wait_bit(input int idx);
      while (tk - 1 < idx) wait_tick();
   endtask

   task automatic wait_past(input int idx);
      while (tk <= idx) @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] d);
      wr_data = d;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic nine,
                                             input logic b8, input logic par, input logic podd);
      logic [10:0] f;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) f[1+i] = d[i];
      if (nine) f[9] = par ? ((^d) ^ podd) : b8;
      else if (par) f[8] = (^d[6:0]) ^ podd;
      return f;
   endfunction

   task automatic check_frame(input int at, input logic [7:0] d, input logic nine,
                              input logic b8, input logic par, input logic podd,
                              input logic inv, input string tag);
      logic [10:0] e, g;
      int len;
      len = nine ? 11 : 10;
      e = exp_frame(d, nine, b8, par, podd);
      g = '1;
      wait_past(at + len);
      for (int i = 0; i < len; i++) g[i] = samp[at+i] ^ inv;
      nchk++;
      if (g !== e) begin
         nfail++;
         $display("FAIL %s: frame at tick %0d got %b expected %b", tag, at, g, e);
      end
   endtask

   task automatic check_ones(input int at, input int n, input logic inv, input string tag);
      int bad;
      bad = 0;
      wait_past(at + n);
      for (int i = 0; i < n; i++) if ((samp[at+i] ^ inv) !== 1'b1) bad++;
      chk(bad == 0, tag, bad, 0);
   endtask

   initial begin
      int s, t0;
      logic [7:0] d;
      logic n9, b8, pe, po, iv;
      void'($urandom(32'h1D1E_5EED));

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1, "R1 txd idle in reset", txd, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R1 txd after reset", txd, 1);
      chk(st_empty === 1'b1, "R1 st_empty after reset", st_empty, 1);
      chk(st_done === 1'b1, "R1 st_done after reset", st_done, 1);
      chk(irq === 1'b0, "R12 irq masked", irq, 0);
      cfg_ie_empty = 1'b1;
      @(negedge clk);
      chk(irq === 1'b1, "R12 irq from empty", irq, 1);

      // preamble and back-to-back frames
      wait_tick();
      tx_en = 1'b1;
      s = tk;
      @(negedge clk);
      chk(st_done === 1'b0, "R11 done low while idle armed", st_done, 0);
      wr_byte(8'hA5);
      chk(st_empty === 1'b0, "R10 write clears empty", st_empty, 0);
      chk(st_done === 1'b0, "R10 write clears done", st_done, 0);
      while (!st_empty) @(negedge clk);
      chk(tk - 1 == s + 10, "R5 empty sets at hand-over tick", tk - 1, s + 10);
      wr_byte(8'h3C);
      check_ones(s, 10, 1'b0, "R4 preamble of 10 ones");
      check_frame(s + 10, 8'hA5, 0, 0, 0, 0, 0, "R2 first frame");
      check_frame(s + 20, 8'h3C, 0, 0, 0, 0, 0, "R5 back-to-back frame");
      check_ones(s + 30, 4, 1'b0, "R2 idle after frames");
      chk(st_done === 1'b1, "R11 done after all sent", st_done, 1);

      // directed modes: parity, nine bits, inversion
      wait_tick(); cfg_par_en = 1; cfg_par_odd = 0; t0 = tk; wr_byte(8'h07);
      check_frame(t0, 8'h07, 0, 0, 1, 0, 0, "R3 even parity 8-bit");
      wait_tick(); cfg_par_odd = 1; t0 = tk; wr_byte(8'h07);
      check_frame(t0, 8'h07, 0, 0, 1, 1, 0, "R3 odd parity 8-bit");
      wait_tick(); cfg_nine = 1; cfg_par_odd = 0; t0 = tk; wr_byte(8'hF1);
      check_frame(t0, 8'hF1, 1, 0, 1, 0, 0, "R3 even parity 9-bit");
      wait_tick(); cfg_par_en = 0; cfg_bit8 = 1; t0 = tk; wr_byte(8'h5A);
      check_frame(t0, 8'h5A, 1, 1, 0, 0, 0, "R2 nine-bit data");
      wait_tick(); cfg_nine = 0; cfg_bit8 = 0; cfg_inv = 1;
      @(negedge clk);
      chk(txd === 1'b0, "R9 inverted idle level", txd, 0);
      wait_tick(); t0 = tk; wr_byte(8'h96);
      check_frame(t0, 8'h96, 0, 0, 0, 0, 1, "R9 inverted frame");
      wait_tick(); cfg_inv = 0;

      // random frames
      for (int k = 0; k < 50; k++) begin
         d  = 8'($urandom);
         n9 = 1'($urandom); b8 = 1'($urandom); pe = 1'($urandom);
         po = 1'($urandom); iv = 1'($urandom_range(0, 3) == 0);
         wait_tick();
         cfg_nine = n9; cfg_bit8 = b8; cfg_par_en = pe; cfg_par_odd = po; cfg_inv = iv;
         t0 = tk;
         wr_byte(d);
         check_frame(t0, d, n9, b8, pe, po, iv, (pe ? "R3 random frame" : "R2 random frame"));
      end
      wait_tick();
      cfg_nine = 0; cfg_par_en = 0; cfg_inv = 0; cfg_bit8 = 0;

      // enable dropped mid-frame and left off
      wait_tick(); t0 = tk; wr_byte(8'hC3);
      while (!st_empty) @(negedge clk);
      wr_byte(8'h18);
      wait_bit(t0 + 3);
      tx_en = 1'b0;
      check_frame(t0, 8'hC3, 0, 0, 0, 0, 0, "R6 frame finishes after disable");
      check_ones(t0 + 10, 20, 1'b0, "R6 line idle while disabled");
      chk(st_empty === 1'b0, "R6 held byte kept", st_empty, 0);

      // re-enable with nothing in flight discards the held byte
      wait_tick();
      tx_en = 1'b1;
      s = tk;
      @(negedge clk);
      chk(st_empty === 1'b1, "R8 held byte discarded", st_empty, 1);
      check_ones(s, 25, 1'b0, "R8 preamble then silence");

      // quick toggle early in frame queues an idle character (9-bit lengths)
      cfg_nine = 1;
      wait_tick(); t0 = tk; wr_byte(8'h81);
      while (!st_empty) @(negedge clk);
      wr_byte(8'h42);
      wait_bit(t0 + 2);
      tx_en = 1'b0;
      @(negedge clk);
      tx_en = 1'b1;
      @(negedge clk);
      chk(st_empty === 1'b0, "R7 toggle keeps held byte", st_empty, 0);
      check_frame(t0, 8'h81, 1, 0, 0, 0, 0, "R7 current frame");
      check_ones(t0 + 11, 11, 1'b0, "R7 queued idle of 11 ones");
      check_frame(t0 + 22, 8'h42, 1, 0, 0, 0, 0, "R7 held byte after idle");
      cfg_nine = 0;

      // toggle during stop bit loses the held byte
      wait_past(t0 + 34);
      wait_tick(); t0 = tk; wr_byte(8'h66);
      while (!st_empty) @(negedge clk);
      wr_byte(8'h99);
      wait_bit(t0 + 9);
      tx_en = 1'b0;
      @(negedge clk);
      tx_en = 1'b1;
      @(negedge clk);
      chk(st_empty === 1'b1, "R8 late toggle discards byte", st_empty, 1);
      check_frame(t0, 8'h66, 0, 0, 0, 0, 0, "R8 frame before late toggle");
      check_ones(t0 + 10, 24, 1'b0, "R8 only idle after late toggle");

      // done interrupt
      cfg_ie_empty = 0; cfg_ie_done = 1;
      @(negedge clk);
      chk(irq === 1'b1, "R12 irq from done", irq, 1);
      wait_tick(); t0 = tk; wr_byte(8'h3F);
      chk(irq === 1'b0, "R12 irq drops on write", irq, 0);
      check_frame(t0, 8'h3F, 0, 0, 0, 0, 0, "R2 final frame");
      wait_tick();
      chk(irq === 1'b1, "R12 irq after completion", irq, 1);

      chk(stab_viol == 0, "R13 line held between ticks", stab_viol, 0);
      summary();
      $finish;
   end
endmodule